// File: doc/BRIEF.md
# Six-Channel Packed TDM Audio Serializer

This block turns six parallel audio sample words into one serial data line, together with the bit clock and a frame clock that marks the left and right halves of each sample period. Three left channels and three right channels share the one data pin. Two packing modes are chosen at run time. The 128 mode uses 128 bit periods per frame with 20-bit data slots and 4-bit blank gaps. The 256 mode uses 256 bit periods per frame with 32-bit slots throughout.

The bit clock is made from the system clock. Each cycle in which `bclk_en` is high is one half-period of the bit clock. On the falling half the serializer moves to its next bit position and updates the frame clock and the data. At the first bit of every frame it loads all six words, the mode and the word length together. It also gives a one-cycle request strobe so the source can present the words for the following frame.

The sequencer is a state machine with five states. `ST_IDLE` is the state after reset. `ST_LEFT` sends the three left slots. `ST_GAP` is the blank between the two groups. `ST_RIGHT` sends the three right slots. `ST_TAIL` is the closing blank. These are its transitions:
- IDLE→LEFT on the first falling bit-clock edge (frame start).
- LEFT→LEFT at the end of left slots 0 and 1 (next channel).
- LEFT→GAP at the end of left slot 2.
- GAP→RIGHT at the end of the gap.
- RIGHT→RIGHT at the end of right slots 0 and 1.
- RIGHT→TAIL at the end of right slot 2.
- TAIL→LEFT at the end of the tail (frame start).

Top module: `tdm_pack_serializer`

## Requirements
- R1: `bclk_o` changes level in the cycle after each cycle in which `bclk_en` is high, and only then. `data_o`, `lrclk_o` and `req_o` change only in a cycle where `bclk_o` goes from 1 to 0.
- R2: With `mode_i`=0 (128 mode) a frame is 128 bit periods. Its layout is left 0, left 1, left 2 (20 bits each), a 4-bit blank, right 0, right 1, right 2 (20 bits each), then a 4-bit blank.
- R3: With `mode_i`=1 (256 mode) a frame is 256 bit periods, made of eight 32-bit slots: left 0, left 1, left 2, blank, right 0, right 1, right 2, blank.
- R4: In 128 mode `lrclk_o` is 1 for the first 64 bit periods and 0 for the last 64. In 256 mode it is 0 for the first 128 and 1 for the last 128.
- R5: Each word is sent MSB first. In 128 mode the MSB is in the first bit of its slot. In 256 mode it is in the second bit, and the first bit of the slot is 0.
- R6: Words are left-justified in `samples_i`: channel c occupies bits [24c+23:24c], with c=0..2 for left 0..2 and c=3..5 for right 0..2. `wlen_i` 0 sends 16 bits, 1 sends 20 bits, and 2 or 3 send 24 bits, taken from bit 23 downward. In 128 mode codes 2 and 3 send 20 bits.
- R7: Bits after the last sent bit of a word, and every bit of a blank slot, are 0.
- R8: All six words are captured at frame start. A change of `samples_i` during a frame does not alter that frame's data.
- R9: A change of `mode_i` or `wlen_i` during a frame takes effect only from the next frame's first bit.
- R10: `req_o` is high for exactly one system cycle, the cycle in which the first bit of each frame appears. The first frame begins at the second `bclk_en` cycle after reset.
- R11: While `rst_n` is low, `bclk_o`, `lrclk_o`, `data_o` and `req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | High for one cycle per bit-clock half-period |
| mode_i | input | 1 | Packing mode: 0 = 128 bit periods, 1 = 256 |
| wlen_i | input | 2 | Word length code: 0 = 16, 1 = 20, 2/3 = 24 |
| samples_i | input | 144 | Six left-justified 24-bit words; channel c at [24c+23:24c] |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock, marks the left and right halves |
| data_o | output | 1 | Serial data, updated on the falling bit-clock edge |
| req_o | output | 1 | One-cycle strobe at the first bit of each frame |

## Verification
The frame boundary is where two functions meet in one cycle. The last bit of the old frame's tail blank is followed at once by a new frame. That frame may use another mode, so the slot width, the MSB delay and the frame-clock polarity all change. In that same cycle the first data bit must come straight from the freshly presented words, while the word bank is still loading. The bench provokes this by switching mode on every frame and writing new words and a new word length just after each frame starts. It judges each bit against an arithmetic frame model that holds the values present at the frame's own start, and it also varies the bit-clock divider.

// File: rtl/tdm_pack_pkg.sv
package tdm_pack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEFT  = 3'd1,
        ST_GAP   = 3'd2,
        ST_RIGHT = 3'd3,
        ST_TAIL  = 3'd4
    } tdm_state_e;

    localparam int LEN_W = 6;

    localparam logic [LEN_W-1:0] LEN_SHORT = 6'd16;
    localparam logic [LEN_W-1:0] LEN_MID   = 6'd20;
    localparam logic [LEN_W-1:0] LEN_FULL  = 6'd24;

    // Number of bits sent per word for a length code and packing mode.
    function automatic logic [LEN_W-1:0] word_len(input logic [1:0] code,
                                                  input logic       wide_mode);
        logic [LEN_W-1:0] len;
        unique case (code)
            2'd0:    len = LEN_SHORT;
            2'd1:    len = LEN_MID;
            default: len = wide_mode ? LEN_FULL : LEN_MID;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic bclk_o,
    output logic fall_o
);

    logic bclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
        end else if (tick_i) begin
            bclk_q <= ~bclk_q;
        end
    end

    assign bclk_o = bclk_q;
    // A tick while the clock is high produces the falling half.
    assign fall_o = tick_i & bclk_q;

endmodule

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_pack_pkg::*;
#(
    parameter int SIDE_CH    = 3,
    parameter int SHORT_SLOT = 20,
    parameter int SHORT_GAP  = 4,
    parameter int LONG_SLOT  = 32,
    localparam int CNT_W     = $clog2(LONG_SLOT),
    localparam int CH_W      = (SIDE_CH > 1) ? $clog2(SIDE_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             wide_mode_i,
    output tdm_state_e       state_o,
    output tdm_state_e       next_state_o,
    output logic [CH_W-1:0]  next_chan_o,
    output logic [CNT_W-1:0] next_bit_o,
    output logic             start_o
);

    localparam logic [CNT_W-1:0] SHORT_SLOT_END = CNT_W'(SHORT_SLOT - 1);
    localparam logic [CNT_W-1:0] SHORT_GAP_END  = CNT_W'(SHORT_GAP - 1);
    localparam logic [CNT_W-1:0] LONG_END       = CNT_W'(LONG_SLOT - 1);
    localparam logic [CH_W-1:0]  LAST_CH        = CH_W'(SIDE_CH - 1);

    tdm_state_e       state_q, state_d;
    logic [CH_W-1:0]  chan_q, chan_d;
    logic [CNT_W-1:0] bit_q, bit_d;
    logic             start_d;
    logic [CNT_W-1:0] slot_end;
    logic [CNT_W-1:0] gap_end;
    logic             slot_done;
    logic             gap_done;

    assign slot_end  = wide_mode_i ? LONG_END : SHORT_SLOT_END;
    assign gap_end   = wide_mode_i ? LONG_END : SHORT_GAP_END;
    assign slot_done = (bit_q == slot_end);
    assign gap_done  = (bit_q == gap_end);

    // Next-position logic, applied on a falling bit-clock half.
    always_comb begin
        state_d = state_q;
        chan_d  = chan_q;
        bit_d   = bit_q + 1'b1;
        start_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_LEFT;
                chan_d  = '0;
                bit_d   = '0;
                start_d = 1'b1;
            end
            ST_LEFT: begin
                if (slot_done) begin
                    bit_d = '0;
                    if (chan_q == LAST_CH) begin
                        state_d = ST_GAP;
                        chan_d  = '0;
                    end else begin
                        chan_d = chan_q + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (gap_done) begin
                    state_d = ST_RIGHT;
                    chan_d  = '0;
                    bit_d   = '0;
                end
            end
            ST_RIGHT: begin
                if (slot_done) begin
                    bit_d = '0;
                    if (chan_q == LAST_CH) begin
                        state_d = ST_TAIL;
                        chan_d  = '0;
                    end else begin
                        chan_d = chan_q + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (gap_done) begin
                    state_d = ST_LEFT;
                    chan_d  = '0;
                    bit_d   = '0;
                    start_d = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                chan_d  = '0;
                bit_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            bit_q   <= '0;
        end else if (fall_i) begin
            state_q <= state_d;
            chan_q  <= chan_d;
            bit_q   <= bit_d;
        end
    end

    assign state_o      = state_q;
    assign next_state_o = state_d;
    assign next_chan_o  = chan_d;
    assign next_bit_o   = bit_d;
    assign start_o      = fall_i & start_d;

endmodule

// File: rtl/tdm_sample_bank.sv
module tdm_sample_bank #(
    parameter int SAMPLE_W = 24,
    parameter int NUM_CH   = 6,
    localparam int BUS_W   = SAMPLE_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BUS_W-1:0] words_i,
    output logic [BUS_W-1:0] words_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_word
        logic [SAMPLE_W-1:0] hold_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= '0;
            end else if (load_i) begin
                hold_q <= words_i[c*SAMPLE_W +: SAMPLE_W];
            end
        end

        assign words_o[c*SAMPLE_W +: SAMPLE_W] = hold_q;
    end

endmodule

// File: rtl/tdm_bit_pick.sv
module tdm_bit_pick
    import tdm_pack_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SIDE_CH   = 3,
    parameter int LONG_SLOT = 32,
    localparam int NUM_CH   = 2 * SIDE_CH,
    localparam int BUS_W    = SAMPLE_W * NUM_CH,
    localparam int CNT_W    = $clog2(LONG_SLOT),
    localparam int CH_W     = (SIDE_CH > 1) ? $clog2(SIDE_CH) : 1,
    localparam int CHI_W    = $clog2(NUM_CH),
    localparam int IDX_W    = $clog2(SAMPLE_W)
) (
    input  tdm_state_e       state_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [CNT_W-1:0] bit_i,
    input  logic             wide_mode_i,
    input  logic [1:0]       wlen_i,
    input  logic [BUS_W-1:0] words_i,
    output logic             data_o,
    output logic             lr_o
);

    logic [SAMPLE_W-1:0] word_arr [NUM_CH];
    logic [CHI_W-1:0]    chi;
    logic [CNT_W-1:0]    delay;
    logic [CNT_W-1:0]    idx;
    logic [IDX_W-1:0]    sel;
    logic [LEN_W-1:0]    len;
    logic                in_data;
    logic                early;
    logic                valid;
    logic                left_level;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_arr
        assign word_arr[c] = words_i[c*SAMPLE_W +: SAMPLE_W];
    end

    always_comb begin
        in_data    = (state_i == ST_LEFT) || (state_i == ST_RIGHT);
        chi        = (state_i == ST_RIGHT) ? CHI_W'(SIDE_CH) + CHI_W'(chan_i)
                                           : CHI_W'(chan_i);
        delay      = {{(CNT_W-1){1'b0}}, wide_mode_i};
        early      = bit_i < delay;
        idx        = bit_i - delay;
        len        = word_len(wlen_i, wide_mode_i);
        valid      = in_data && !early && ({1'b0, idx} < len);
        sel        = IDX_W'(SAMPLE_W - 1) - idx[IDX_W-1:0];
        data_o     = valid ? word_arr[chi][sel] : 1'b0;
        left_level = !wide_mode_i;
        lr_o       = ((state_i == ST_LEFT) || (state_i == ST_GAP)) ? left_level
                                                                   : !left_level;
    end

endmodule

// File: rtl/tdm_pack_serializer.sv
module tdm_pack_serializer
    import tdm_pack_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int SIDE_CH    = 3,
    parameter int SHORT_SLOT = 20,
    parameter int SHORT_GAP  = 4,
    parameter int LONG_SLOT  = 32,
    localparam int NUM_CH    = 2 * SIDE_CH,
    localparam int BUS_W     = SAMPLE_W * NUM_CH,
    localparam int CNT_W     = $clog2(LONG_SLOT),
    localparam int CH_W      = (SIDE_CH > 1) ? $clog2(SIDE_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_en,
    input  logic             mode_i,
    input  logic [1:0]       wlen_i,
    input  logic [BUS_W-1:0] samples_i,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             data_o,
    output logic             req_o
);

    logic             fall;
    logic             start;
    tdm_state_e       state_q;
    tdm_state_e       next_state;
    logic [CH_W-1:0]  next_chan;
    logic [CNT_W-1:0] next_bit;
    logic [BUS_W-1:0] bank_words;
    logic [BUS_W-1:0] eff_words;
    logic             mode_q;
    logic [1:0]       wlen_q;
    logic             eff_mode;
    logic [1:0]       eff_wlen;
    logic             pick_data;
    logic             pick_lr;
    logic             data_q;
    logic             lr_q;
    logic             req_q;

    tdm_bclk_gen u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (bclk_en),
        .bclk_o (bclk_o),
        .fall_o (fall)
    );

    tdm_frame_fsm #(
        .SIDE_CH    (SIDE_CH),
        .SHORT_SLOT (SHORT_SLOT),
        .SHORT_GAP  (SHORT_GAP),
        .LONG_SLOT  (LONG_SLOT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fall_i       (fall),
        .wide_mode_i  (mode_q),
        .state_o      (state_q),
        .next_state_o (next_state),
        .next_chan_o  (next_chan),
        .next_bit_o   (next_bit),
        .start_o      (start)
    );

    tdm_sample_bank #(
        .SAMPLE_W (SAMPLE_W),
        .NUM_CH   (NUM_CH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start),
        .words_i (samples_i),
        .words_o (bank_words)
    );

    // Frame configuration captured together with the words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            wlen_q <= '0;
        end else if (start) begin
            mode_q <= mode_i;
            wlen_q <= wlen_i;
        end
    end

    // The first bit of a frame is taken straight from the inputs.
    assign eff_words = start ? samples_i : bank_words;
    assign eff_mode  = start ? mode_i    : mode_q;
    assign eff_wlen  = start ? wlen_i    : wlen_q;

    tdm_bit_pick #(
        .SAMPLE_W  (SAMPLE_W),
        .SIDE_CH   (SIDE_CH),
        .LONG_SLOT (LONG_SLOT)
    ) u_pick (
        .state_i     (next_state),
        .chan_i      (next_chan),
        .bit_i       (next_bit),
        .wide_mode_i (eff_mode),
        .wlen_i      (eff_wlen),
        .words_i     (eff_words),
        .data_o      (pick_data),
        .lr_o        (pick_lr)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 1'b0;
            lr_q   <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            req_q <= start;
            if (fall) begin
                data_q <= pick_data;
                lr_q   <= pick_lr;
            end
        end
    end

    assign lrclk_o = lr_q;
    assign data_o  = data_q;
    assign req_o   = req_q;

endmodule

// File: rtl/tdm_pack_serializer_chk.sv
module tdm_pack_serializer_chk
    import tdm_pack_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bclk_en,
    input logic       bclk_o,
    input logic       lrclk_o,
    input logic       data_o,
    input logic       req_o,
    input tdm_state_e cur_state
);

    // R1: the bit clock flips after every enable cycle.
    p_bclk_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_en |=> (bclk_o != $past(bclk_o)));

    // R1: without an enable the bit clock holds.
    p_bclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_en |=> $stable(bclk_o));

    // R1: data moves only with a falling bit clock.
    p_data_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> $fell(bclk_o));

    // R4: frame clock moves only with a falling bit clock.
    p_lr_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk_o) |-> $fell(bclk_o));

    // R10: the request strobe lasts one cycle.
    p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R10: the request strobe coincides with a bit boundary.
    p_req_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $fell(bclk_o));

    // R10: a frame always opens in the left group.
    p_req_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (cur_state == ST_LEFT));

    // R7: blank slots carry zeros.
    p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bclk_o) && ((cur_state == ST_GAP) || (cur_state == ST_TAIL))) |-> !data_o);

endmodule

bind tdm_pack_serializer tdm_pack_serializer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_en   (bclk_en),
    .bclk_o    (bclk_o),
    .lrclk_o   (lrclk_o),
    .data_o    (data_o),
    .req_o     (req_o),
    .cur_state (state_q)
);

// File: tb/tdm_pack_serializer_bench.sv
module tdm_pack_serializer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 24;
    localparam int NCH        = 6;
    localparam int NFRAMES    = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bclk_en = 1'b0;
    logic           mode = 1'b0;
    logic [1:0]     wlen = 2'd0;
    logic [NCH*SW-1:0] samples = '0;
    logic           bclk_o, lrclk_o, data_o, req_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    int  div = 2;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_pack_serializer u_tdm_pack_serializer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_en   (bclk_en),
        .mode_i    (mode),
        .wlen_i    (wlen),
        .samples_i (samples),
        .bclk_o    (bclk_o),
        .lrclk_o   (lrclk_o),
        .data_o    (data_o),
        .req_o     (req_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [SW-1:0] gen_word(input int f, input int ch);
        logic [31:0] t;
        t = 32'hA5C3F1 ^ (f * 32'h1357B) ^ (ch * 32'h2468B) ^ (32'(ch) << 20);
        return t[SW-1:0];
    endfunction

    function automatic int frame_len(input logic m);
        return m ? 256 : 128;
    endfunction

    function automatic int wl_of(input logic m, input logic [1:0] wc);
        if (wc == 2'd0) return 16;
        if (wc == 2'd1) return 20;
        return m ? 24 : 20;
    endfunction

    function automatic logic exp_lr(input logic m, input int pos);
        if (pos < frame_len(m) / 2) return !m;
        return m;
    endfunction

    function automatic logic exp_data(input logic m, input logic [1:0] wc,
                                      input logic [NCH*SW-1:0] ws, input int pos);
        int half, sw, d, p, slot, k, idx, ch;
        half = frame_len(m) / 2;
        sw   = m ? 32 : 20;
        d    = m ? 1 : 0;
        p    = pos % half;
        slot = p / sw;
        if (slot >= 3) return 1'b0;
        k = p % sw;
        if (k < d) return 1'b0;
        idx = k - d;
        if (idx >= wl_of(m, wc)) return 1'b0;
        ch = slot + ((pos >= half) ? 3 : 0);
        return ws[ch*SW + SW - 1 - idx];
    endfunction

    function automatic bit is_blank(input logic m, input logic [1:0] wc, input int pos);
        int half, sw, d, p, k;
        half = frame_len(m) / 2;
        sw   = m ? 32 : 20;
        d    = m ? 1 : 0;
        p    = pos % half;
        if (p / sw >= 3) return 1'b1;
        k = p % sw;
        return (k < d) || (k - d >= wl_of(m, wc));
    endfunction

    task automatic apply_cfg(input int f);
        mode = f[0];
        wlen = 2'((f / 2) % 4);
        for (int ch = 0; ch < NCH; ch++) samples[ch*SW +: SW] = gen_word(f, ch);
    endtask

    initial begin : main
        logic exp_bclk, prev_bclk, prev_data, prev_lr, fell, en;
        logic fm, cur_m;
        logic [1:0] fw, cur_w;
        logic [NCH*SW-1:0] fs, cur_s;
        int cyc, pos, frame;
        string tag;

        apply_cfg(0);
        cur_m = mode; cur_w = wlen; cur_s = samples;
        fm = cur_m; fw = cur_w; fs = cur_s;
        repeat (4) begin
            @(negedge clk);
            check("R11 bclk", bclk_o, 1'b0);
            check("R11 lrclk", lrclk_o, 1'b0);
            check("R11 data", data_o, 1'b0);
            check("R11 req", req_o, 1'b0);
        end
        rst_n = 1'b1;
        exp_bclk = 0; prev_bclk = 0; prev_data = 0; prev_lr = 0;
        cyc = 0; pos = -1; frame = -1; div = 2;

        while (frame < NFRAMES) begin
            en = ((cyc % div) == 0);
            bclk_en = en;
            exp_bclk = exp_bclk ^ en;
            cyc++;
            @(negedge clk);
            check("R1 bclk", bclk_o, exp_bclk);
            fell = prev_bclk && !bclk_o;
            if (fell) begin
                pos++;
                if (frame < 0 || pos == frame_len(fm)) begin
                    frame++;
                    pos = 0;
                    if (frame >= NFRAMES) break;
                    fm = cur_m; fw = cur_w; fs = cur_s;
                    div = 2 + ((frame / 8) % 2);
                    if (frame + 1 < NFRAMES) begin
                        apply_cfg(frame + 1);
                        cur_m = mode; cur_w = wlen; cur_s = samples;
                    end
                end
                check("R10 req", req_o, pos == 0);
                if (is_blank(fm, fw, pos)) tag = "R7 data";
                else tag = fm ? "R3/R5/R6/R8 data" : "R2/R5/R6/R8 data";
                check(tag, data_o, exp_data(fm, fw, fs, pos));
                check("R4/R9 lrclk", lrclk_o, exp_lr(fm, pos));
            end else begin
                check("R1 data hold", data_o, prev_data);
                check("R1 lrclk hold", lrclk_o, prev_lr);
                check("R10 req idle", req_o, 1'b0);
            end
            prev_bclk = bclk_o;
            prev_data = data_o;
            prev_lr = lrclk_o;
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule